// File: doc/BRIEF.md
# Compressor-Tree Multiply-Accumulate Unit

This block computes `a * b + c` for two 4-bit unsigned operands and an 8-bit unsigned addend in one merged reduction. The product is never formed on its own. Each operand-bit pair is combined by an AND gate into a weighted partial-product bit, the addend's bits are dropped into the same weighted bit matrix, and a single column-by-column tree of 3:2 full-adder cells reduces that matrix to one 8-bit row.

The reduction starts at the least significant column and moves toward the most significant. In each column it repeatedly feeds three bits into a full adder. The sum bit returns to the same column and the carry bit moves to the next column. This repeats until one bit is left in the column. A column that still has exactly two bits is finished by a full adder whose third input is tied low. A carry out of the top column is dropped, so the result is modulo 256. A parameter places an optional register on the result. The register is present by default and has a synchronous active-high reset.

Top module: `mac_csa_unit`

## Requirements
- R1: With the output register enabled, `result` equals `(mul_a * mul_b + acc_in) mod 256` of the operands captured at the previous rising clock edge, all values unsigned.
- R2: When either multiplicand is zero, `result` equals `acc_in` exactly, with no contribution from the other operand.
- R3: A total above 255 wraps: the carry beyond bit 7 is discarded (for example 15*15+255 gives 224).
- R4: When `mul_b` is 1, only the unshifted copy of `mul_a` contributes, so `result` equals `(mul_a + acc_in) mod 256`.
- R5: While `rst` is high at a rising edge, the registered `result` becomes 0 at that edge, whatever the operands are.
- R6: If the operands are held unchanged across consecutive edges outside reset, `result` stays unchanged.
- R7: The largest operands with a zero addend (15*15+0) give the full product 225 with no wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the optional result register |
| rst | input | 1 | Synchronous active-high reset of the result register |
| mul_a | input | 4 | Unsigned multiplicand |
| mul_b | input | 4 | Unsigned multiplier; bit k gates the row shifted by k |
| acc_in | input | 8 | Unsigned addend merged into the bit matrix |
| result | output | 8 | (mul_a*mul_b + acc_in) mod 256 |

## Verification
The bench uses the default configuration, which has the output register. Every result is therefore due exactly one rising edge after its operands are captured. Operands are driven on a falling edge and `result` is sampled on the next falling edge, half a period after the capturing rising edge, so no vector overlaps the one before it. The reset and hold checks keep to the same falling-edge sampling over several edges.

// File: rtl/mac_pkg.sv
package mac_pkg;

    localparam int MAC_A_W   = 4;
    localparam int MAC_B_W   = 4;
    localparam int MAC_RES_W = 8;

    typedef struct packed {
        logic carry;
        logic sum;
    } fa_out_t;

    // One 3:2 counter cell: sum stays in the column, carry moves up one weight
    function automatic fa_out_t full_add(input logic x, input logic y, input logic z);
        fa_out_t r;
        r.sum   = x ^ y ^ z;
        r.carry = (x & y) | (x & z) | (y & z);
        return r;
    endfunction

    // True when matrix row r holds a real bit at column c.
    // Rows below bw are shifted partial products; row bw is the addend.
    function automatic logic bit_live(input int r, input int c, input int aw, input int bw);
        if (r < bw)
            return (c >= r) && (c - r < aw);
        return 1'b1;
    endfunction

endpackage

// File: rtl/mac_ppgen.sv
module mac_ppgen #(
    parameter int A_W   = 4,
    parameter int B_W   = 4,
    parameter int RES_W = 8
) (
    input  logic [A_W-1:0]                mul_a,
    input  logic [B_W-1:0]                mul_b,
    output logic [B_W-1:0][RES_W-1:0]     pp_rows
);

    // Row k: multiplicand shifted left by k, each bit ANDed with multiplier bit k
    for (genvar k = 0; k < B_W; k++) begin : g_row
        for (genvar c = 0; c < RES_W; c++) begin : g_col
            if (c >= k && c - k < A_W) begin : g_and
                assign pp_rows[k][c] = mul_a[c-k] & mul_b[k];
            end else begin : g_zero
                assign pp_rows[k][c] = 1'b0;
            end
        end
    end

endmodule

// File: rtl/mac_csa_reduce.sv
module mac_csa_reduce
    import mac_pkg::*;
#(
    parameter int A_W   = 4,
    parameter int B_W   = 4,
    parameter int RES_W = 8
) (
    input  logic [B_W:0][RES_W-1:0] matrix,
    output logic [RES_W-1:0]        sum_out
);

    localparam int ROWS  = B_W + 1;
    localparam int DEPTH = 2 * ROWS + 2;
    localparam int IDX_W = $clog2(DEPTH + 1);
    localparam int SLOTS = 2 ** IDX_W;

    always_comb begin
        logic [SLOTS-1:0] colbits [RES_W+1];
        logic [IDX_W-1:0] cnt     [RES_W+1];
        logic             x, y, z;
        fa_out_t          fo;

        for (int c = 0; c <= RES_W; c++) begin
            colbits[c] = '0;
            cnt[c]     = '0;
        end
        x  = 1'b0;
        y  = 1'b0;
        z  = 1'b0;
        fo = '0;

        // Load every live bit of the merged matrix into its column
        for (int r = 0; r < ROWS; r++) begin
            for (int c = 0; c < RES_W; c++) begin
                if (bit_live(r, c, A_W, B_W)) begin
                    colbits[c][cnt[c]] = matrix[r][c];
                    cnt[c]             = cnt[c] + IDX_W'(1);
                end
            end
        end

        // Column-wise 3:2 reduction, least significant column first
        for (int c = 0; c < RES_W; c++) begin
            for (int it = 0; it < DEPTH; it++) begin
                if (cnt[c] > IDX_W'(1)) begin
                    x = colbits[c][cnt[c] - IDX_W'(1)];
                    y = colbits[c][cnt[c] - IDX_W'(2)];
                    z = (cnt[c] > IDX_W'(2)) ? colbits[c][cnt[c] - IDX_W'(3)] : 1'b0;
                    fo = full_add(x, y, z);
                    cnt[c] = (cnt[c] > IDX_W'(2)) ? cnt[c] - IDX_W'(3) : cnt[c] - IDX_W'(2);
                    colbits[c][cnt[c]] = fo.sum;
                    cnt[c]             = cnt[c] + IDX_W'(1);
                    // column RES_W is a sink: its carries fall off the result
                    colbits[c+1][cnt[c+1]] = fo.carry;
                    cnt[c+1]               = cnt[c+1] + IDX_W'(1);
                end
            end
        end

        for (int c = 0; c < RES_W; c++) begin
            sum_out[c] = (cnt[c] != '0) ? colbits[c][0] : 1'b0;
        end
    end

endmodule

// File: rtl/mac_out_stage.sv
module mac_out_stage #(
    parameter int W       = 8,
    parameter bit REG_OUT = 1'b1
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) q <= '0;
            else     q <= d;
        end
    end else begin : g_wire
        assign q = d;
    end

endmodule

// File: rtl/mac_csa_unit.sv
module mac_csa_unit
    import mac_pkg::*;
#(
    parameter int A_W     = MAC_A_W,
    parameter int B_W     = MAC_B_W,
    parameter int RES_W   = MAC_RES_W,
    parameter bit REG_OUT = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [A_W-1:0]   mul_a,
    input  logic [B_W-1:0]   mul_b,
    input  logic [RES_W-1:0] acc_in,
    output logic [RES_W-1:0] result
);

    logic [B_W-1:0][RES_W-1:0] pp_rows;
    logic [B_W:0][RES_W-1:0]   matrix;
    logic [RES_W-1:0]          tree_sum;

    mac_ppgen #(.A_W(A_W), .B_W(B_W), .RES_W(RES_W)) u_ppgen (
        .mul_a   (mul_a),
        .mul_b   (mul_b),
        .pp_rows (pp_rows)
    );

    // Addend occupies the top row of the same bit matrix
    assign matrix = {acc_in, pp_rows};

    mac_csa_reduce #(.A_W(A_W), .B_W(B_W), .RES_W(RES_W)) u_reduce (
        .matrix  (matrix),
        .sum_out (tree_sum)
    );

    mac_out_stage #(.W(RES_W), .REG_OUT(REG_OUT)) u_out (
        .clk (clk),
        .rst (rst),
        .d   (tree_sum),
        .q   (result)
    );

endmodule

// File: rtl/mac_csa_checker.sv
module mac_csa_checker #(
    parameter int A_W     = 4,
    parameter int B_W     = 4,
    parameter int RES_W   = 8,
    parameter bit REG_OUT = 1'b1
) (
    input logic             clk,
    input logic             rst,
    input logic [A_W-1:0]   mul_a,
    input logic [B_W-1:0]   mul_b,
    input logic [RES_W-1:0] acc_in,
    input logic [RES_W-1:0] result
);

    logic [RES_W:0] full_sum;
    assign full_sum = (RES_W+1)'(mul_a) * (RES_W+1)'(mul_b) + (RES_W+1)'(acc_in);

    if (REG_OUT) begin : g_chk
        assert_mac_value_R1: assert property (@(posedge clk) disable iff (rst)
            $past(!rst) |-> result == $past(full_sum[RES_W-1:0]));

        assert_zero_operand_R2: assert property (@(posedge clk) disable iff (rst)
            ($past(!rst) && ($past(mul_a) == '0 || $past(mul_b) == '0))
            |-> result == $past(acc_in));

        assert_wrap_R3: assert property (@(posedge clk) disable iff (rst)
            ($past(!rst) && $past(full_sum[RES_W]))
            |-> result == $past(full_sum[RES_W-1:0]));

        assert_reset_clear_R5: assert property (@(posedge clk)
            rst |=> result == '0);

        assert_hold_stable_R6: assert property (@(posedge clk) disable iff (rst)
            (!rst && $past(!rst) && $stable(mul_a) && $stable(mul_b) && $stable(acc_in))
            |=> $stable(result));
    end

endmodule

bind mac_csa_unit mac_csa_checker #(
    .A_W(A_W), .B_W(B_W), .RES_W(RES_W), .REG_OUT(REG_OUT)
) u_chk (
    .clk    (clk),
    .rst    (rst),
    .mul_a  (mul_a),
    .mul_b  (mul_b),
    .acc_in (acc_in),
    .result (result)
);

// File: tb/mac_csa_unit_test.sv
`timescale 1ns/1ps
module mac_csa_unit_test;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] mul_a = '0;
    logic [3:0] mul_b = '0;
    logic [7:0] acc_in = '0;
    logic [7:0] result;

    int n_checks = 0;
    int n_fails  = 0;

    always #10 clk = ~clk;

    mac_csa_unit uut (
        .clk    (clk),
        .rst    (rst),
        .mul_a  (mul_a),
        .mul_b  (mul_b),
        .acc_in (acc_in),
        .result (result)
    );

    function automatic logic [7:0] model(input int a, input int b, input int c);
        int t;
        t = a * b + c;
        return 8'(t % 256);
    endfunction

    task automatic check(input logic [7:0] got, input logic [7:0] exp, input string req);
        n_checks++;
        if (got !== exp) begin
            n_fails++;
            $display("FAIL %s: result=%0d expected=%0d (a=%0d b=%0d c=%0d)",
                     req, got, exp, mul_a, mul_b, acc_in);
        end
    endtask

    // drive on a falling edge, capture at the rising edge, sample on the next falling edge
    task automatic apply(input int a, input int b, input int c, input string req);
        @(negedge clk);
        mul_a  = 4'(a);
        mul_b  = 4'(b);
        acc_in = 8'(c);
        @(negedge clk);
        check(result, model(a, b, c), req);
    endtask

    initial begin
        #4000000;
        n_fails++;
        $display("FAIL watchdog: run did not finish, actual=timeout expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2718));
        // R5: reset clears the register with busy operands
        mul_a = 4'd13; mul_b = 4'd11; acc_in = 8'd99;
        repeat (3) @(negedge clk);
        check(result, 8'd0, "R5");
        @(negedge clk);
        check(result, 8'd0, "R5");
        rst = 1'b0;

        // directed corners
        apply(15, 15, 255, "R3");
        apply(15, 15, 0,   "R7");
        apply(0, 15, 200,  "R2");
        apply(9, 0, 77,    "R2");
        apply(11, 1, 250,  "R4");
        apply(7, 1, 3,     "R4");
        apply(10, 5, 1,    "R1");

        // R6: hold operands across several edges
        apply(12, 13, 40, "R6");
        repeat (3) begin
            @(negedge clk);
            check(result, model(12, 13, 40), "R6");
        end

        // sweep of all operand pairs across 16 addend values
        for (int a = 0; a < 16; a++) begin
            for (int b = 0; b < 16; b++) begin
                for (int k = 0; k < 16; k++) begin
                    int c;
                    c = k * 17;
                    if (a == 0 || b == 0)          apply(a, b, c, "R2");
                    else if (a * b + c > 255)      apply(a, b, c, "R3");
                    else if (b == 1)               apply(a, b, c, "R4");
                    else                           apply(a, b, c, "R1");
                end
            end
        end

        // random vectors
        for (int i = 0; i < 1500; i++) begin
            apply(int'($urandom % 16), int'($urandom % 16), int'($urandom % 256), "R1");
        end

        // R5 again mid-run
        @(negedge clk);
        rst = 1'b1;
        mul_a = 4'd15; mul_b = 4'd15; acc_in = 8'd1;
        @(negedge clk);
        check(result, 8'd0, "R5");
        rst = 1'b0;
        apply(3, 4, 5, "R1");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule